// File: doc/BRIEF.md
# Three-Stage Interlocked Toy Processor Core

This core runs a four-operation accumulator-style program held in an external instruction memory. Each instruction passes through three stages. In fetch, the word at the program counter is latched. In execute, the source register is read and the result is formed. In store, the result is written to the register file or presented on the data-memory write port. While the program has no dependencies, one instruction enters the core every clock.

There is no forwarding path, so a register result becomes readable only once its store stage has ended. When the instruction in execute reads the register that the instruction just ahead of it is still writing, interlock logic freezes the program counter and the fetch register for one cycle. It fills the execute-to-store slot with a bubble that writes nothing, and instructions already ahead keep moving. An all-ones instruction word halts the core: once it reaches execute, fetching stops for good, the older instructions drain, and a sticky halted flag is raised.

Top module: `trio_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` and `halted` are 0, even if the core was halted before the reset.
- R2: An instruction is 16 bits: opcode in [15:14], destination register in [13:12], source register in [11:10], reserved in [9:8], immediate or address in [7:0]. STORE (opcode 11) drives the source register's value on `dmem_wdata`, with `dmem_addr` equal to bits [7:0] and `dmem_we` high for one cycle.
- R3: LOAD (00) writes the immediate to the destination register. MOVE (01) copies the source register. ADD (10) writes source plus immediate, modulo 256. All four 8-bit registers are zero after reset.
- R4: With no stalls, instruction k (counting from 0) drives its memory write in the cycle after the (k+2)-th rising edge that follows reset release, so a new instruction is accepted every clock.
- R5: When MOVE, ADD or STORE reads the register written by the instruction directly before it, exactly one bubble is inserted. That instruction and every later one are delayed by one cycle, and `imem_addr` holds during the bubble.
- R6: No bubble is inserted when the producer is two or more instructions earlier, when only the destinations match, when the consumer is a LOAD, or when the preceding instruction is a STORE.
- R7: A bubble performs no register write and no memory write. The only memory writes are those of the program's STORE instructions.
- R8: The word 0xFFFF halts the core. `halted` rises in the cycle after the (h+2+b)-th rising edge, where h is the halt word's index and b is the number of bubbles before it, and it stays high. No instruction after the halt word executes, and `imem_addr` stops changing.
- R9: The reserved bits [9:8] have no effect on any instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 8 | Instruction memory read address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | 8 | Data memory write address |
| dmem_wdata | output | 8 | Data memory write data |
| halted | output | 1 | Core has executed the halt word |

## Verification
Five short programs are run, each from a fresh reset, against a sequential model of the instruction set that predicts every memory write together with the cycle in which it appears.

- A chain in which every instruction depends on the one before checks the one-bubble interlock and how its delay accumulates.
- A run of independent loads and stores separates single-cycle issue from any stray stall.
- A mix of distance-two dependencies, destination-only overlaps and modulo-256 adds shows the interlock firing only on a true adjacent read-after-write.
- A program with reserved bits set and a store placed after the halt word shows that the reserved field is ignored and that nothing past the halt executes.

// File: rtl/trio_pkg.sv
package trio_pkg;

  localparam int unsigned INSN_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned REG_N     = 4;
  localparam int unsigned REG_IDX_W = $clog2(REG_N);
  localparam int unsigned RSVD_W    = INSN_W - 2 - 2 * REG_IDX_W - DATA_W;

  typedef enum logic [1:0] {
    OP_LDI  = 2'b00,
    OP_CPY  = 2'b01,
    OP_ADDI = 2'b10,
    OP_STM  = 2'b11
  } opcode_e;

  typedef struct packed {
    opcode_e              op;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs;
    logic [RSVD_W-1:0]    rsvd;
    logic [DATA_W-1:0]    imm;
  } insn_t;

  localparam logic [INSN_W-1:0] HALT_WORD = '1;

  // fetch-to-execute slot
  typedef struct packed {
    logic  vld;
    insn_t insn;
  } fslot_t;

  // execute-to-store slot
  typedef struct packed {
    logic                 reg_we;
    logic                 mem_we;
    logic [REG_IDX_W-1:0] rd;
    logic [DATA_W-1:0]    addr;
    logic [DATA_W-1:0]    data;
  } wslot_t;

  localparam fslot_t FSLOT_NOP = '0;
  localparam wslot_t WSLOT_NOP = '0;

  function automatic logic reads_src(insn_t i);
    return i.op != OP_LDI;
  endfunction

endpackage

// File: rtl/trio_fetch.sv
module trio_fetch
  import trio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [INSN_W-1:0] imem_data,
  output logic [ADDR_W-1:0] pc,
  output fslot_t            fx,
  output logic              halted,
  output logic              fx_is_halt
);

  logic [ADDR_W-1:0] pc_d;
  fslot_t            fx_d;
  logic              halted_d;
  logic              fetch_en;

  assign fx_is_halt = fx.vld && (fx.insn == HALT_WORD);
  assign fetch_en   = !stall && !halted && !fx_is_halt;

  always_comb begin
    pc_d     = pc;
    fx_d     = fx;
    halted_d = halted;
    if (halted || fx_is_halt) begin
      fx_d     = FSLOT_NOP;
      halted_d = 1'b1;
    end else if (fetch_en) begin
      pc_d     = pc + ADDR_W'(1);
      fx_d.vld = 1'b1;
      fx_d.insn = insn_t'(imem_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      fx     <= FSLOT_NOP;
      halted <= 1'b0;
    end else begin
      pc     <= pc_d;
      fx     <= fx_d;
      halted <= halted_d;
    end
  end

endmodule

// File: rtl/trio_hazard.sv
module trio_hazard
  import trio_pkg::*;
(
  input  fslot_t fx,
  input  logic   fx_is_halt,
  input  wslot_t xs,
  output logic   stall
);

  logic consumer;

  assign consumer = fx.vld && !fx_is_halt && reads_src(fx.insn);
  assign stall    = consumer && xs.reg_we && (xs.rd == fx.insn.rs);

endmodule

// File: rtl/trio_regfile.sv
module trio_regfile
  import trio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] waddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [REG_IDX_W-1:0] raddr,
  output logic [DATA_W-1:0]    rdata
);

  logic [DATA_W-1:0] bank [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = we && (waddr == REG_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign bank[g] = q;
  end

  // no write-through: a same-cycle write is seen on the next cycle
  assign rdata = bank[raddr];

endmodule

// File: rtl/trio_exec.sv
module trio_exec
  import trio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fslot_t            fx,
  input  logic              fx_is_halt,
  input  logic              stall,
  input  logic [DATA_W-1:0] src_val,
  output wslot_t            xs
);

  wslot_t xs_d;

  always_comb begin
    xs_d = WSLOT_NOP;
    if (fx.vld && !stall && !fx_is_halt) begin
      xs_d.rd   = fx.insn.rd;
      xs_d.addr = fx.insn.imm;
      unique case (fx.insn.op)
        OP_LDI: begin
          xs_d.reg_we = 1'b1;
          xs_d.data   = fx.insn.imm;
        end
        OP_CPY: begin
          xs_d.reg_we = 1'b1;
          xs_d.data   = src_val;
        end
        OP_ADDI: begin
          xs_d.reg_we = 1'b1;
          xs_d.data   = src_val + fx.insn.imm;
        end
        OP_STM: begin
          xs_d.mem_we = 1'b1;
          xs_d.data   = src_val;
        end
        default: xs_d = WSLOT_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xs <= WSLOT_NOP;
    else        xs <= xs_d;
  end

endmodule

// File: rtl/trio_core.sv
module trio_core
  import trio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [INSN_W-1:0] imem_data,
  output logic              dmem_we,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              halted
);

  fslot_t            fx;
  wslot_t            xs;
  logic              stall;
  logic              fx_is_halt;
  logic [DATA_W-1:0] src_val;

  trio_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .imem_data  (imem_data),
    .pc         (imem_addr),
    .fx         (fx),
    .halted     (halted),
    .fx_is_halt (fx_is_halt)
  );

  trio_hazard u_hazard (
    .fx         (fx),
    .fx_is_halt (fx_is_halt),
    .xs         (xs),
    .stall      (stall)
  );

  trio_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (xs.reg_we),
    .waddr (xs.rd),
    .wdata (xs.data),
    .raddr (fx.insn.rs),
    .rdata (src_val)
  );

  trio_exec u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .fx         (fx),
    .fx_is_halt (fx_is_halt),
    .stall      (stall),
    .src_val    (src_val),
    .xs         (xs)
  );

  assign dmem_we    = xs.mem_we;
  assign dmem_addr  = xs.addr;
  assign dmem_wdata = xs.data;

endmodule

// File: rtl/trio_core_chk.sv
module trio_core_chk
  import trio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              halted,
  input logic              fx_is_halt,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              dmem_we
);

  assert_stall_holds_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(imem_addr));

  assert_bubble_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !dmem_we);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_freezes_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr));

  assert_issue_every_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !halted && !fx_is_halt) |=> (imem_addr == $past(imem_addr) + ADDR_W'(1)));

endmodule

bind trio_core trio_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .halted     (halted),
  .fx_is_halt (fx_is_halt),
  .imem_addr  (imem_addr),
  .dmem_we    (dmem_we)
);

// File: tb/trio_core_test.sv
module trio_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic        dmem_we;
  logic [7:0]  dmem_addr;
  logic [7:0]  dmem_wdata;
  logic        halted;

  always #5 clk = ~clk;

  trio_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .halted     (halted)
  );

  logic [15:0] prog [32];
  assign imem_data = (imem_addr < 8'd32) ? prog[imem_addr[4:0]] : 16'hFFFF;

  int cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  typedef struct {
    int a;
    int d;
    int c;
  } exp_t;

  exp_t  sb[$];
  int    compared = 0;
  int    mismatched = 0;
  int    halt_seen = -1;
  string dtag = "R2";
  string ttag = "R4";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int op, input int rd, input int rs,
                                     input int imm, input int rsvd = 0);
    return {op[1:0], rd[1:0], rs[1:0], rsvd[1:0], imm[7:0]};
  endfunction

  // sequential model of the instruction set, with the interlock timing rule
  task automatic plan(output int exp_halt);
    int regs [4];
    int b = 0;
    bit prev_wr = 0;
    int prev_rd = 0;
    exp_halt = -1;
    foreach (regs[i]) regs[i] = 0;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] w;
      int op, rd, rs, imm;
      w = prog[i];
      if (w == 16'hFFFF) begin
        exp_halt = i + 2 + b;
        break;
      end
      op = int'(w[15:14]); rd = int'(w[13:12]); rs = int'(w[11:10]); imm = int'(w[7:0]);
      if (op != 0 && prev_wr && prev_rd == rs) b++;
      case (op)
        0: regs[rd] = imm;
        1: regs[rd] = regs[rs];
        2: regs[rd] = (regs[rs] + imm) % 256;
        default: begin
          exp_t e;
          e.a = imm; e.d = regs[rs]; e.c = i + 2 + b;
          sb.push_back(e);
        end
      endcase
      prev_wr = (op != 3);
      prev_rd = rd;
    end
  endtask

  // monitor: pop and compare every memory write as it appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (dmem_we) begin
        if (sb.size() == 0) begin
          check(1'b0, halted ? "R8" : "R7", "unexpected write addr", int'(dmem_addr), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(dmem_addr) == e.a, dtag, "write address", int'(dmem_addr), e.a);
          check(int'(dmem_wdata) == e.d, dtag, "write data", int'(dmem_wdata), e.d);
          check(cyc == e.c, ttag, "write cycle", cyc, e.c);
        end
      end
      if (halted && halt_seen < 0) halt_seen = cyc;
    end
  end

  task automatic run(input string dt, input string tt);
    int exp_halt;
    logic [7:0] frozen;
    rst_n = 1'b0;
    sb.delete();
    @(negedge clk);
    check(imem_addr == 8'd0, "R1", "imem_addr in reset", int'(imem_addr), 0);
    check(!dmem_we, "R1", "dmem_we in reset", int'(dmem_we), 0);
    check(!halted, "R1", "halted in reset", int'(halted), 0);
    dtag = dt; ttag = tt; halt_seen = -1;
    plan(exp_halt);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 300 && halt_seen < 0; i++) @(negedge clk);
    if (halt_seen < 0) check(1'b0, "R8", "watchdog: halt never seen", -1, exp_halt);
    frozen = imem_addr;
    repeat (4) @(negedge clk);
    check(halt_seen == exp_halt, "R8", "halt cycle", halt_seen, exp_halt);
    check(halted, "R8", "halted sticky", int'(halted), 1);
    check(imem_addr == frozen, "R8", "fetch frozen", int'(imem_addr), int'(frozen));
    check(sb.size() == 0, "R7", "missing writes", sb.size(), 0);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "R8", "global watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    foreach (prog[i]) prog[i] = 16'hFFFF;

    // R3 R5: fully dependent chain, one bubble per link
    prog[0] = mk(0, 0, 0, 40);
    prog[1] = mk(1, 1, 0, 0);
    prog[2] = mk(2, 1, 1, 20);
    prog[3] = mk(3, 0, 1, 8'h30);
    prog[4] = 16'hFFFF;
    run("R3", "R5");

    // R2 R4: independent loads and stores, one per clock
    foreach (prog[i]) prog[i] = 16'hFFFF;
    prog[0] = mk(0, 0, 0, 5);
    prog[1] = mk(0, 1, 0, 7);
    prog[2] = mk(0, 2, 0, 9);
    prog[3] = mk(0, 3, 0, 8'hA5);
    prog[4] = mk(3, 0, 0, 8'h10);
    prog[5] = mk(3, 0, 1, 8'h11);
    prog[6] = mk(3, 0, 2, 8'h12);
    prog[7] = mk(3, 0, 3, 8'hFF);
    run("R2", "R4");

    // R6 R3: distance-two use, destination-only overlap, wrapping add
    foreach (prog[i]) prog[i] = 16'hFFFF;
    prog[0] = mk(0, 3, 0, 250);
    prog[1] = mk(0, 0, 0, 0);
    prog[2] = mk(2, 2, 3, 10);
    prog[3] = mk(0, 1, 0, 1);
    prog[4] = mk(1, 1, 0, 0);
    prog[5] = mk(3, 0, 2, 8'h20);
    prog[6] = mk(3, 0, 1, 8'h21);
    run("R3", "R6");

    // R9 R8: reserved bits set, store after halt must not run
    foreach (prog[i]) prog[i] = 16'hFFFF;
    prog[0] = mk(0, 2, 0, 8'h3C, 3);
    prog[1] = mk(2, 2, 2, 1, 2);
    prog[2] = mk(3, 0, 2, 8'h40, 1);
    prog[3] = 16'hFFFF;
    prog[4] = mk(3, 0, 2, 8'h77);
    prog[5] = mk(0, 0, 0, 1);
    run("R9", "R5");

    // R5 R6 R3: store consumer stalls, store producer never causes a stall
    foreach (prog[i]) prog[i] = 16'hFFFF;
    prog[0] = mk(0, 0, 0, 8'h81);
    prog[1] = mk(3, 0, 0, 8'h50);
    prog[2] = mk(2, 0, 0, 8'h7F);
    prog[3] = mk(3, 0, 0, 8'h51);
    run("R3", "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule